// File: doc/BRIEF.md
# Converter Serial Port Emulator

This block models the digital side of a 12-bit successive-approximation converter's serial port. It runs on a fast system clock and samples two host pins: an active-low chip-select and a serial clock. A host frame starts when chip-select falls. The block then shifts out four zero bits and the 12-bit sample, MSB first, on a serial data line. The data line has its own output enable.

The block also models the converter's power state. It decides between normal operation, an aborted conversion, entering power-down, and waking up. The decision depends on how many serial-clock falling edges the host gives before it raises chip-select again. A track/hold flag and a powered flag report the modelled analog state. After a wake, a ready flag asserts once a programmable number of system clocks has passed.

Both host pins pass through a two-flop synchroniser and an edge detector before anything counts them. Every pin change therefore takes effect three system clocks later.

Top module: `sar_serial_port`

## Requirements
- R1: After reset with START_POWERED=1, the outputs read powered=1, ready=1, track=1 and sdo_oe=0. With START_POWERED=0 they read powered=0, ready=0, track=0 and sdo_oe=0.
- R2: A chip-select fall sets sdo_oe=1 and sdo=0, the first leading zero. In a powered frame it also sets track=0 (hold).
- R3: The frame word is {4'b0000, sample}. After the k-th serial-clock fall (k = 1..15), sdo carries word bit 15-k, so bits go out MSB first.
- R4: On the 16th serial-clock fall, sdo_oe drops to 0. Further serial-clock edges in the same frame leave it at 0.
- R5: In a powered frame, track stays 0 after the 13th serial-clock fall. It becomes 1 after the serial-clock rise that follows that fall.
- R6: A chip-select rise before the 16th fall ends the frame with sdo_oe=0.
- R7: In a powered frame, a chip-select rise after 2 to 9 falls enters power-down, with powered=0 and track=0. A rise after 0 or 1 falls, or after 10 or more, keeps powered=1 with track=1.
- R8: From power-down, a frame that reaches 10 falls sets powered=1. A frame that ends with fewer falls leaves powered=0 and track=0.
- R9: In a wake frame, track becomes 1 at the first serial-clock edge, and the 12 result bits are all zero.
- R10: ready is 0 while powered down. It rises POWERUP_CLKS system clocks after the wake frame's chip-select fall is seen, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_in | input | 1 | Host chip-select, active low, asynchronous |
| sclk_in | input | 1 | Host serial clock, asynchronous |
| sample_in | input | DATA_W | Sample captured at the frame start |
| sdo | output | 1 | Serial data, driven 0 while disabled |
| sdo_oe | output | 1 | Output enable for the serial data line |
| track | output | 1 | 1 = track, 0 = hold |
| powered | output | 1 | 1 = normal mode, 0 = power-down |
| ready | output | 1 | Power-up time has elapsed |

## Verification
The main input pattern is the length of the frame. The bench sweeps every count of serial-clock falls from 0 to 18 in a powered frame. This separates the stay-powered band, the power-down band, the full frame and the edges that arrive after the frame is complete. Each time the block powers down, it is woken twice: first by a short frame that must leave it asleep, then by a long frame that must wake it. This separates the two wake outcomes and checks that ready waits for its timer. Each sweep step uses a different sample value, so every bit position is checked in both states.

// File: rtl/sar_serial_port.sv
module sar_serial_port #(
  parameter int DATA_W        = 12,
  parameter int LEAD_ZEROS    = 4,
  parameter int TRACK_AFTER   = 13,
  parameter int SLEEP_MIN     = 2,
  parameter int WAKE_MIN      = 10,
  parameter int POWERUP_CLKS  = 200,
  parameter bit START_POWERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_in,
  input  logic              sclk_in,
  input  logic [DATA_W-1:0] sample_in,
  output logic              sdo,
  output logic              sdo_oe,
  output logic              track,
  output logic              powered,
  output logic              ready
);
  localparam int FRAME_LEN = DATA_W + LEAD_ZEROS;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam int TMR_W     = $clog2(POWERUP_CLKS + 1);
  localparam logic [TMR_W-1:0] TMR_MAX = TMR_W'(POWERUP_CLKS);

  logic [1:0] cs_sync, sck_sync;
  logic       cs_d, sck_d;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_sync  <= 2'b11;
      sck_sync <= 2'b11;
      cs_d     <= 1'b1;
      sck_d    <= 1'b1;
    end else begin
      cs_sync  <= {cs_sync[0], cs_n_in};
      sck_sync <= {sck_sync[0], sclk_in};
      cs_d     <= cs_sync[1];
      sck_d    <= sck_sync[1];
    end

  wire cs_fall  =  cs_d  & ~cs_sync[1];
  wire cs_rise  = ~cs_d  &  cs_sync[1];
  wire sck_fall =  sck_d & ~sck_sync[1];
  wire sck_rise = ~sck_d &  sck_sync[1];

  logic                 in_frame, wake_frm, armed, pwr, trk;
  logic [CNT_W-1:0]     cnt;
  logic [FRAME_LEN-1:0] shreg;
  logic [TMR_W-1:0]     timer;

  wire [CNT_W-1:0] cnt_nx = cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_frame <= 1'b0;
      wake_frm <= 1'b0;
      armed    <= 1'b0;
      pwr      <= START_POWERED;
      trk      <= START_POWERED;
      cnt      <= '0;
      shreg    <= '0;
    end else if (cs_fall) begin
      in_frame <= 1'b1;
      wake_frm <= ~pwr;
      armed    <= 1'b0;
      trk      <= 1'b0;
      cnt      <= '0;
      shreg    <= {{LEAD_ZEROS{1'b0}}, pwr ? sample_in : {DATA_W{1'b0}}};
    end else if (cs_rise) begin
      if (in_frame) begin
        in_frame <= 1'b0;
        wake_frm <= 1'b0;
        if (wake_frm) begin
          if (!pwr) trk <= 1'b0;
        end else if (cnt >= CNT_W'(SLEEP_MIN) && cnt < CNT_W'(WAKE_MIN)) begin
          pwr <= 1'b0;
          trk <= 1'b0;
        end else begin
          trk <= 1'b1;
        end
      end
    end else if (in_frame) begin
      if (sck_fall) begin
        cnt   <= cnt_nx;
        shreg <= shreg << 1;
        if (cnt_nx == CNT_W'(TRACK_AFTER)) armed <= 1'b1;
        if (wake_frm) trk <= 1'b1;
        if (wake_frm && cnt_nx == CNT_W'(WAKE_MIN)) pwr <= 1'b1;
        if (cnt_nx == CNT_W'(FRAME_LEN)) begin
          in_frame <= 1'b0;
          wake_frm <= 1'b0;
        end
      end
      if (sck_rise && (armed || wake_frm)) trk <= 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      timer <= START_POWERED ? TMR_MAX : '0;
    else if (!pwr && !(in_frame && wake_frm))
      timer <= '0;
    else if (timer != TMR_MAX)
      timer <= timer + 1'b1;

  assign sdo_oe  = in_frame;
  assign sdo     = in_frame & shreg[FRAME_LEN-1];
  assign track   = trk;
  assign powered = pwr;
  assign ready   = pwr && (timer == TMR_MAX);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt <= CNT_W'(FRAME_LEN)); // R4
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) cs_rise |=> !sdo_oe); // R6
  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (!rst_n) $rose(sdo_oe) |-> !sdo); // R2
  AST_DOWN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (!pwr && !in_frame) |-> !trk); // R7
  AST_READY_NEEDS_POWER: assert property (@(posedge clk) disable iff (!rst_n) $rose(ready) |-> $past(pwr || wake_frm)); // R10
endmodule

// File: tb/sar_serial_port_tb.sv
`timescale 1ns/1ps
module sar_serial_port_tb_top;
  localparam int PUP = 200;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1, sck = 1'b1;
  logic [11:0] smp = '0;
  logic sdo, oe, trk, pwr, rdy;
  logic sdo2, oe2, trk2, pwr2, rdy2;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sar_serial_port #(.POWERUP_CLKS(PUP), .START_POWERED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n_in(cs_n), .sclk_in(sck), .sample_in(smp),
    .sdo(sdo), .sdo_oe(oe), .track(trk), .powered(pwr), .ready(rdy));

  sar_serial_port #(.POWERUP_CLKS(PUP), .START_POWERED(1'b0)) dut_pd_i (
    .clk(clk), .rst_n(rst_n), .cs_n_in(1'b1), .sclk_in(1'b1), .sample_in(12'h000),
    .sdo(sdo2), .sdo_oe(oe2), .track(trk2), .powered(pwr2), .ready(rdy2));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_cs(bit v); cs_n = v; tick(5); endtask
  task automatic set_sck(bit v); sck = v; tick(5); endtask

  task automatic frame(int n, logic [11:0] s, bit wake);
    logic [15:0] word;
    word = wake ? 16'h0000 : {4'b0000, s};
    smp = s;
    set_cs(1'b0);
    chk("R2 oe at start", oe, 1);
    chk("R2 first zero", sdo, 0);
    if (!wake) chk("R2 hold at start", trk, 0);
    for (int k = 1; k <= n; k++) begin
      set_sck(1'b0);
      if (k < 16) begin
        chk(wake ? "R9 zero result bit" : "R3 bit order", sdo, word[15-k]);
        chk("R3 oe in frame", oe, 1);
      end else chk("R4 released after 16th", oe, 0);
      if (wake) chk("R9 track at first edge", trk, 1);
      if (!wake && k == 13) chk("R5 hold after 13th fall", trk, 0);
      set_sck(1'b1);
      if (!wake && k == 13) chk("R5 track after rise", trk, 1);
    end
    set_cs(1'b1);
    chk("R6 released at end", oe, 0);
  endtask

  initial begin
    tick(3);
    chk("R1 powered", pwr, 1);
    chk("R1 ready", rdy, 1);
    chk("R1 track", trk, 1);
    chk("R1 oe", oe, 0);
    chk("R1 pd powered", pwr2, 0);
    chk("R1 pd ready", rdy2, 0);
    chk("R1 pd track", trk2, 0);
    chk("R1 pd oe", oe2, 0);
    rst_n = 1'b1;
    tick(4);
    for (int n = 0; n <= 18; n++) begin
      logic [11:0] s;
      bit down;
      s = 12'(n * 12'h1B7) ^ 12'hA5C;
      down = (n >= 2 && n < 10);
      frame(n, s, 1'b0);
      chk("R7 power state", pwr, down ? 0 : 1);
      chk("R7 track after frame", trk, down ? 0 : 1);
      if (down) begin
        chk("R10 ready low when down", rdy, 0);
        frame(n % 10, ~s, 1'b1);
        chk("R8 short wake stays down", pwr, 0);
        chk("R8 short wake holds", trk, 0);
        chk("R10 ready low after short wake", rdy, 0);
        frame(10 + n % 7, s, 1'b1);
        chk("R8 long wake powers up", pwr, 1);
        chk("R10 ready not yet", rdy, 0);
        tick(PUP);
        chk("R10 ready after timer", rdy, 1);
      end else chk("R10 ready kept", rdy, 1);
    end
    chk("R1 pd instance idle", pwr2, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule